// File: doc/BRIEF.md
# Eight-Pin Edge Event Collector

This block watches eight asynchronous input pins and records a sticky event flag per pin when an edge of the selected kind is seen. Each pin carries its own 2-bit edge mode, so a pin can ignore all edges, react to rising edges only, react to falling edges only, or react to both. The pins are brought into the clock domain through a two-flop synchronizer. An edge is found by comparing the synchronized level with its level one cycle earlier.

Software reaches three 8-bit registers over a simple synchronous bus with address, write data, write enable and read data. The registers are one flag register and two mode registers, each mode register holding four 2-bit fields. A flag can be cleared only by writing 0 to its bit. The block drives the flag vector and a single request line that is high while any flag is set. Priority, vectoring and acknowledge belong to the interrupt controller that consumes these outputs.

Top module: `eint_edge_ctrl`

## Requirements
- R1: After synchronous reset, the flag register and both mode registers read 0x00, the flag output is 0x00 and the request output is low.
- R2: With mode 01 a pin's flag is set by a 0-to-1 transition of the pin, and a 1-to-0 transition does not set it.
- R3: With mode 10 a pin's flag is set by a 1-to-0 transition, and a 0-to-1 transition does not set it.
- R4: With mode 11 a pin's flag is set by a transition in either direction.
- R5: With mode 00 no transition of the pin sets its flag.
- R6: A set flag stays set across later cycles and further edges until software clears it.
- R7: A write to address 0xC0 clears each flag bit whose write-data bit is 0. Flag bits whose write-data bit is 1 keep their value.
- R8: When an edge event and a clearing write hit the same flag bit in the same cycle, the flag ends up set.
- R9: The request output is high exactly when at least one flag bit is set.
- R10: Address 0xA4 holds the modes of pins 0 to 3 and address 0xA5 holds the modes of pins 4 to 7. Pin n uses bits [2(n mod 4)+1 : 2(n mod 4)] of its register. Both registers read back what was written to them.
- R11: Address 0xC0 reads the flag register. Any other address outside 0xC0, 0xA4 and 0xA5 reads 0x00, and writes to it change nothing.
- R12: A pin level change applied before clock edge k shows up in the flag register after edge k+2, and it is not visible after edge k+1.
- R13: Rewriting a pin's mode leaves flags that are already set unchanged. Only edges detected after the write use the new mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eint_i | input | 8 | Asynchronous event pins, bit n is pin n |
| bus_addr_i | input | 8 | Register address |
| bus_wdata_i | input | 8 | Register write data |
| bus_we_i | input | 1 | Write enable, sampled on the clock edge |
| bus_rdata_o | output | 8 | Read data for the current address (combinational) |
| flags_o | output | 8 | Sticky event flags |
| irq_o | output | 1 | High while any flag is set |

## Verification
Several rules are checked by the embedded assertions on every cycle. A new flag bit needs an event in the cycle before it. A flag bit can only drop under a clearing write with a 0 in that bit. An event always leaves its flag set, even when a clear arrives in the same cycle. The mode registers hold their value unless written. A synchronized rise must trace back to the pin level exactly two and three cycles earlier. Only the bench's scenarios show which mode selects which edge direction, the field position of each pin in the mode registers, the absence of effect from unmapped addresses, and that a mode change leaves earlier flags alone. The bench checks these against its own cycle model, over directed cases and a seeded random mix of pin toggles and bus writes.

// File: rtl/eint_pkg.sv
package eint_pkg;

    localparam int unsigned EINT_PINS      = 8;
    localparam int unsigned BUS_DATA_W     = 8;
    localparam int unsigned BUS_ADDR_W     = 8;
    localparam int unsigned MODE_W         = 2;
    localparam int unsigned FIELDS_PER_REG = BUS_DATA_W / MODE_W;
    localparam int unsigned MODE_VEC_W     = EINT_PINS * MODE_W;

    localparam logic [BUS_ADDR_W-1:0] ADDR_FLAGS   = 8'hC0;
    localparam logic [BUS_ADDR_W-1:0] ADDR_MODE_LO = 8'hA4;
    localparam logic [BUS_ADDR_W-1:0] ADDR_MODE_HI = 8'hA5;

    typedef enum logic [MODE_W-1:0] {
        EM_OFF  = 2'b00,
        EM_RISE = 2'b01,
        EM_FALL = 2'b10,
        EM_BOTH = 2'b11
    } edge_mode_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_pair_t;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_FLAGS,
        SEL_MODE_LO,
        SEL_MODE_HI
    } reg_sel_e;

    function automatic logic edge_hit(input edge_mode_e mode, input edge_pair_t seen);
        logic hit;
        case (mode)
            EM_RISE: hit = seen.rise;
            EM_FALL: hit = seen.fall;
            EM_BOTH: hit = seen.rise | seen.fall;
            default: hit = 1'b0;
        endcase
        return hit;
    endfunction

    function automatic reg_sel_e decode_addr(input logic [BUS_ADDR_W-1:0] addr);
        reg_sel_e sel;
        case (addr)
            ADDR_FLAGS:   sel = SEL_FLAGS;
            ADDR_MODE_LO: sel = SEL_MODE_LO;
            ADDR_MODE_HI: sel = SEL_MODE_HI;
            default:      sel = SEL_NONE;
        endcase
        return sel;
    endfunction

endpackage

// File: rtl/eint_sync.sv
module eint_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);

    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] chain_q;
    logic [WIDTH-1:0]             prev_q;
    logic [WIDTH-1:0]             level;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= pin_i;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign level = chain_q[LAST];

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
        end else begin
            prev_q <= level;
        end
    end

    assign rise_o = level & ~prev_q;
    assign fall_o = ~level & prev_q;

    generate
        if (STAGES == 2) begin : g_latency_chk
            logic [1:0] arm_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    arm_q <= '0;
                end else if (arm_q != 2'd3) begin
                    arm_q <= arm_q + 2'd1;
                end
            end
            for (genvar b = 0; b < WIDTH; b++) begin : g_bit
                AST_RISE_LATENCY: assert property (@(posedge clk) disable iff (rst)
                    (arm_q == 2'd3 && rise_o[b]) |-> ($past(pin_i[b], 2) && !$past(pin_i[b], 3))); // R12
            end
        end
    endgenerate

endmodule

// File: rtl/eint_edge_sel.sv
module eint_edge_sel
    import eint_pkg::*;
#(
    parameter int unsigned PINS = EINT_PINS
) (
    input  logic [PINS*MODE_W-1:0] modes_i,
    input  logic [PINS-1:0]        rise_i,
    input  logic [PINS-1:0]        fall_i,
    output logic [PINS-1:0]        evt_o
);

    generate
        for (genvar p = 0; p < PINS; p++) begin : g_pin
            edge_mode_e mode;
            edge_pair_t seen;
            assign mode = edge_mode_e'(modes_i[p*MODE_W +: MODE_W]);
            assign seen = '{rise: rise_i[p], fall: fall_i[p]};
            assign evt_o[p] = edge_hit(mode, seen);
        end
    endgenerate

endmodule

// File: rtl/eint_regs.sv
module eint_regs
    import eint_pkg::*;
#(
    parameter int unsigned PINS = EINT_PINS
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [BUS_ADDR_W-1:0] addr_i,
    input  logic [BUS_DATA_W-1:0] wdata_i,
    input  logic                  we_i,
    input  logic [PINS-1:0]       evt_i,
    output logic [PINS*MODE_W-1:0] modes_o,
    output logic [PINS-1:0]       flags_o,
    output logic [BUS_DATA_W-1:0] rdata_o
);

    reg_sel_e              sel;
    logic                  wr_flags;
    logic [PINS-1:0]       clr_mask;
    logic [PINS-1:0]       flags_q;
    logic [PINS-1:0]       flags_d;
    logic [BUS_DATA_W-1:0] mode_lo_q;
    logic [BUS_DATA_W-1:0] mode_hi_q;
    logic                  chk_armed_q;

    assign sel      = decode_addr(addr_i);
    assign wr_flags = we_i && (sel == SEL_FLAGS);
    assign clr_mask = wr_flags ? ~wdata_i[PINS-1:0] : '0;
    assign flags_d  = (flags_q & ~clr_mask) | evt_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_lo_q <= '0;
            mode_hi_q <= '0;
        end else if (we_i) begin
            if (sel == SEL_MODE_LO) mode_lo_q <= wdata_i;
            if (sel == SEL_MODE_HI) mode_hi_q <= wdata_i;
        end
    end

    always_comb begin
        case (sel)
            SEL_FLAGS:   rdata_o = BUS_DATA_W'(flags_q);
            SEL_MODE_LO: rdata_o = mode_lo_q;
            SEL_MODE_HI: rdata_o = mode_hi_q;
            default:     rdata_o = '0;
        endcase
    end

    assign modes_o = {mode_hi_q, mode_lo_q};
    assign flags_o = flags_q;

    always_ff @(posedge clk) begin
        if (rst) chk_armed_q <= 1'b0;
        else     chk_armed_q <= 1'b1;
    end

    AST_SET_NEEDS_EVENT: assert property (@(posedge clk) disable iff (rst)
        chk_armed_q |-> ((flags_q & ~$past(flags_q) & ~$past(evt_i)) == '0)); // R6
    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
        chk_armed_q |-> (($past(evt_i) & ~flags_q) == '0)); // R8
    AST_CLEAR_BY_ZERO: assert property (@(posedge clk) disable iff (rst)
        chk_armed_q |-> (($past(flags_q) & ~flags_q & ~$past(clr_mask)) == '0)); // R7
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (chk_armed_q && !$past(we_i)) |-> $stable(modes_o)); // R10

endmodule

// File: rtl/eint_edge_ctrl.sv
module eint_edge_ctrl
    import eint_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [EINT_PINS-1:0]  eint_i,
    input  logic [BUS_ADDR_W-1:0] bus_addr_i,
    input  logic [BUS_DATA_W-1:0] bus_wdata_i,
    input  logic                  bus_we_i,
    output logic [BUS_DATA_W-1:0] bus_rdata_o,
    output logic [EINT_PINS-1:0]  flags_o,
    output logic                  irq_o
);

    logic [EINT_PINS-1:0]  rise;
    logic [EINT_PINS-1:0]  fall;
    logic [EINT_PINS-1:0]  evt;
    logic [MODE_VEC_W-1:0] modes;

    eint_sync #(
        .WIDTH  (EINT_PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (eint_i),
        .rise_o (rise),
        .fall_o (fall)
    );

    eint_edge_sel #(
        .PINS (EINT_PINS)
    ) u_sel (
        .modes_i (modes),
        .rise_i  (rise),
        .fall_i  (fall),
        .evt_o   (evt)
    );

    eint_regs #(
        .PINS (EINT_PINS)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .addr_i  (bus_addr_i),
        .wdata_i (bus_wdata_i),
        .we_i    (bus_we_i),
        .evt_i   (evt),
        .modes_o (modes),
        .flags_o (flags_o),
        .rdata_o (bus_rdata_o)
    );

    assign irq_o = |flags_o;

    AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> ($past(evt) != '0)); // R9
    AST_IRQ_FALL_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_o) |-> $past(bus_we_i)); // R9

endmodule

// File: tb/tb_eint_edge_ctrl.sv
module tb_eint_edge_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] eint = '0;
    logic [7:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       we = 1'b0;
    logic [7:0] rdata;
    logic [7:0] flags;
    logic       irq;

    int unsigned n_checks = 0;
    int unsigned n_errors = 0;

    // bench model, built from R1..R13
    logic [7:0] m_s1, m_s2, m_prev, m_flags, m_lo, m_hi;

    always #10 clk = ~clk;

    eint_edge_ctrl dut (
        .clk         (clk),
        .rst         (rst),
        .eint_i      (eint),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_we_i    (we),
        .bus_rdata_o (rdata),
        .flags_o     (flags),
        .irq_o       (irq)
    );

    function automatic logic [1:0] mode_of(input int n, input logic [7:0] lo, input logic [7:0] hi);
        logic [7:0] r;
        r = (n < 4) ? lo : hi;
        return r[2*(n%4) +: 2];
    endfunction

    function automatic logic [7:0] model_events();
        logic [7:0] e;
        for (int n = 0; n < 8; n++) begin
            logic up, dn;
            up = m_s2[n] & ~m_prev[n];
            dn = ~m_s2[n] & m_prev[n];
            case (mode_of(n, m_lo, m_hi))
                2'b01:   e[n] = up;
                2'b10:   e[n] = dn;
                2'b11:   e[n] = up | dn;
                default: e[n] = 1'b0;
            endcase
        end
        return e;
    endfunction

    function automatic logic [7:0] model_read(input logic [7:0] a);
        case (a)
            8'hC0:   return m_flags;
            8'hA4:   return m_lo;
            8'hA5:   return m_hi;
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [7:0] pins, input logic w, input logic [7:0] a, input logic [7:0] d);
        logic [7:0] ev, clr;
        @(negedge clk);
        eint = pins; we = w; addr = a; wdata = d;
        ev  = model_events();
        clr = (w && a == 8'hC0) ? ~d : 8'h00;
        @(posedge clk);
        #1;
        m_flags = (m_flags & ~clr) | ev;
        if (w && a == 8'hA4) m_lo = d;
        if (w && a == 8'hA5) m_hi = d;
        m_prev = m_s2; m_s2 = m_s1; m_s1 = pins;
    endtask

    task automatic idle(input logic [7:0] a);
        step(eint, 1'b0, a, 8'h00);
    endtask

    task automatic compare_all(input string tag);
        #2;
        check({tag, " flags"}, flags, m_flags);
        check({tag, " rdata"}, rdata, model_read(addr));
        check({tag, " irq R9"}, {7'd0, irq}, {7'd0, (m_flags != 0)});
    endtask

    initial begin
        #(20 * 150000);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd424242));
        m_s1 = 0; m_s2 = 0; m_prev = 0; m_flags = 0; m_lo = 0; m_hi = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        idle(8'hC0); #2 check("R1 flag reg", rdata, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);
        idle(8'hA4); #2 check("R1 mode lo", rdata, 8'h00);
        idle(8'hA5); #2 check("R1 mode hi", rdata, 8'h00);

        // R10 field layout: pin0 off, pin1 rise, pin2 fall, pin3 both, pin4 rise
        step(8'h00, 1'b1, 8'hA4, 8'b11_10_01_00);
        step(8'h00, 1'b1, 8'hA5, 8'b00_00_00_01);
        idle(8'hA4); #2 check("R10 lo readback", rdata, 8'hE4);
        idle(8'hA5); #2 check("R10 hi readback", rdata, 8'h01);

        // R12 latency, R2 R4 R5 on rising edges of pins 0..4
        step(8'h1F, 1'b0, 8'hC0, 8'h00);
        idle(8'hC0); #2 check("R12 not yet after k+1", flags, 8'h00);
        idle(8'hC0); #2 check("R2 R4 R5 rise set", flags, 8'h1A);
        check("R9 irq high", {7'd0, irq}, 8'h01);

        // R7 write ones no effect, write zero clears
        step(8'h1F, 1'b1, 8'hC0, 8'hFF);
        #2 check("R7 ones keep", flags, 8'h1A);
        step(8'h1F, 1'b1, 8'hC0, 8'hFD);
        #2 check("R7 zero clears pin1", flags, 8'h18);

        // R6 stays set; R3 falling edges
        repeat (4) idle(8'hC0);
        #2 check("R6 sticky", flags, 8'h18);
        step(8'h00, 1'b0, 8'hC0, 8'h00);
        idle(8'hC0); idle(8'hC0);
        #2 check("R3 R2 fall", flags, 8'h1C);

        // R13 mode change keeps flags
        step(8'h00, 1'b1, 8'hA4, 8'h00);
        step(8'h00, 1'b1, 8'hA5, 8'h00);
        #2 check("R13 flags kept", flags, 8'h1C);
        step(8'h00, 1'b1, 8'hC0, 8'h00);
        #2 check("R7 clear all", flags, 8'h00);
        check("R9 irq low", {7'd0, irq}, 8'h00);

        // R8 event and clear in the same cycle on pin1 (rise)
        step(8'h00, 1'b1, 8'hA4, 8'b00_00_01_00);
        step(8'h02, 1'b0, 8'hC0, 8'h00);
        idle(8'hC0);
        step(8'h02, 1'b1, 8'hC0, 8'h00);
        #2 check("R8 event wins", flags, 8'h02);

        // R11 unmapped address
        step(8'h02, 1'b1, 8'h10, 8'h00);
        #2 check("R11 unmapped read", rdata, 8'h00);
        check("R11 unmapped write", flags, 8'h02);
        idle(8'hA4); #2 check("R11 mode untouched", rdata, 8'h04);

        // random mix against the model
        for (int i = 0; i < 1500; i++) begin
            logic [7:0] pins, a, d;
            logic       w;
            int unsigned r;
            r = $urandom % 8;
            pins = ($urandom % 3 == 0) ? 8'($urandom) : eint;
            w = ($urandom % 4 == 0);
            case (r)
                0, 1, 2: a = 8'hC0;
                3, 4:    a = 8'hA4;
                5, 6:    a = 8'hA5;
                default: a = 8'($urandom);
            endcase
            d = (a == 8'hC0) ? (8'($urandom) | 8'($urandom)) : 8'($urandom);
            step(pins, w, a, d);
            compare_all("R2 R3 R4 R5 R7 R8 R11 R13 random");
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule